// File: doc/BRIEF.md
# Conditional ALU with NZCV Status Flags

This block is the data-processing stage of a small 32-bit integer core. Each issued operation carries a 4-bit opcode, a 4-bit condition field, two operands, a request to update the flags and the carry bit from an external operand shifter. The block first tests the condition against its own registered N, Z, C and V flags. When the test fails, the operation has no effect: nothing is written back and the flags stay as they were.

When the condition passes, the block computes the result in the same cycle. The operations are arithmetic with and without carry-in, reversed subtraction, bitwise logic, bit clear and moves. A register-write enable goes out with the result. The flag register updates on the next rising clock edge when flags were requested. The four compare and test opcodes always update the flags and never write a result.

The flags are also presented as a 32-bit status word with N, Z, C and V in its top four bits.

Top module: `cond_alu`

## Requirements
- R1: After reset is asserted, `flags_o` is 4'b0000 and `status_o` is zero.
- R2: Condition codes, with pass rules: 0000 Z set; 0001 Z clear; 0010 C set; 0011 C clear; 0100 N set; 0101 N clear; 0110 V set; 0111 V clear; 1000 C set and Z clear; 1001 C clear or Z set; 1010 N equals V; 1011 N differs from V; 1100 (GT) Z clear and N equals V; 1101 Z set or N differs from V; 1110 always; 1111 never.
- R3: When a valid operation fails its condition, `wr_en_o` is low and the flags do not change at the next edge, even for compare opcodes or a set-flags request.
- R4: Opcode 0100 (ADD) gives a+b, 0010 (SUB) gives a-b, and 0011 (RSB) gives b-a. With flags requested: N is result bit 31, Z is set for a zero result, C is the carry out (for subtraction, 1 means no borrow), and V is signed overflow.
- R5: Opcode 0101 (ADC) gives a+b+C. Opcode 0110 (SBC) gives a-b-(1-C). Opcode 0111 (RSC) gives b-a-(1-C). C is the registered carry flag. The flag rules of R4 apply.
- R6: Logic opcodes: 0000 AND gives a&b, 0001 EOR gives a^b, 1100 ORR gives a|b, 1101 MOV gives b, 1110 BIC gives a&~b, 1111 MVN gives ~b.
- R7: A logic opcode that updates the flags sets N and Z from its result and C from `shift_carry_i`, and leaves V unchanged.
- R8: Opcodes 1000 (TST, a&b), 1001 (TEQ, a^b), 1010 (CMP, a-b) and 1011 (CMN, a+b) never raise `wr_en_o`. When their condition passes, they update the flags whatever the value of `set_flags_i`.
- R9: A passing data opcode with `set_flags_i` low raises `wr_en_o` and leaves the flags unchanged.
- R10: The flags change only at a rising edge that has `op_valid_i` high. `status_o` holds N, Z, C, V in bits 31, 30, 29, 28, and its other bits are zero.
- R11: `result_o` and `wr_en_o` are combinational in the current inputs and the registered flags. The flag effect of an operation shows on `flags_o` after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation is issued this cycle |
| opcode_i | input | 4 | Operation select |
| cond_i | input | 4 | Condition field |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| set_flags_i | input | 1 | Request a flag update for data opcodes |
| shift_carry_i | input | 1 | Shifter carry-out, used as C for logic opcodes |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Write back result_o |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |
| status_o | output | 32 | Status word, flags in bits 31:28 |

## Verification
The hardest part to reach from the ports is the full condition table. Each code must be judged against flag combinations that only earlier operations can create, for example N and V both set with Z clear. The bench builds five distinct flag states with chosen compare and compare-negative operations: Z and C set, N only, C only, N with V, and C with V. In each state it issues a non-flag-setting move under all sixteen codes and compares the write enable against a pass mask worked out by hand. The carry-in forms are also tested under both values of C, by clearing C with a borrowing compare.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int unsigned FLAG_W = 4;

endpackage

// File: rtl/cond_alu_cond.sv
module cond_alu_cond
  import cond_alu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  nzcv_t      flags_i,
  output logic       pass_o
);

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_EQ:   pass_o = flags_i.z;
      CC_NE:   pass_o = ~flags_i.z;
      CC_CS:   pass_o = flags_i.c;
      CC_CC:   pass_o = ~flags_i.c;
      CC_MI:   pass_o = flags_i.n;
      CC_PL:   pass_o = ~flags_i.n;
      CC_VS:   pass_o = flags_i.v;
      CC_VC:   pass_o = ~flags_i.v;
      CC_HI:   pass_o = flags_i.c & ~flags_i.z;
      CC_LS:   pass_o = ~flags_i.c | flags_i.z;
      CC_GE:   pass_o = flags_i.n == flags_i.v;
      CC_LT:   pass_o = flags_i.n != flags_i.v;
      CC_GT:   pass_o = ~flags_i.z & (flags_i.n == flags_i.v);
      CC_LE:   pass_o = flags_i.z | (flags_i.n != flags_i.v);
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;  // reserved code never executes
    endcase
  end

endmodule

// File: rtl/cond_alu_adder.sv
module cond_alu_adder #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W:0] full;

  always_comb begin
    full   = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
    sum_o  = full[MSB:0];
    cout_o = full[DATA_W];
    ovf_o  = (x_i[MSB] == y_i[MSB]) && (full[MSB] != x_i[MSB]);
  end

endmodule

// File: rtl/cond_alu_exec.sv
module cond_alu_exec
  import cond_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [3:0]        opcode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  nzcv_t             flags_i,
  input  logic              shift_carry_i,
  output logic [DATA_W-1:0] result_o,
  output nzcv_t             flags_o,
  output logic              is_cmp_o,
  output logic              is_logic_o
);

  localparam int unsigned MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] add_x, add_y, add_sum;
  logic              add_cin, add_cout, add_ovf;
  logic [DATA_W-1:0] logic_res;

  assign op = alu_op_e'(opcode_i);

  // adder operand steering: subtraction as x + ~y + cin
  always_comb begin
    add_x   = a_i;
    add_y   = b_i;
    add_cin = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: begin add_x = a_i; add_y = b_i;  add_cin = 1'b0;      end
      OP_ADC:         begin add_x = a_i; add_y = b_i;  add_cin = flags_i.c; end
      OP_SUB, OP_CMP: begin add_x = a_i; add_y = ~b_i; add_cin = 1'b1;      end
      OP_SBC:         begin add_x = a_i; add_y = ~b_i; add_cin = flags_i.c; end
      OP_RSB:         begin add_x = b_i; add_y = ~a_i; add_cin = 1'b1;      end
      OP_RSC:         begin add_x = b_i; add_y = ~a_i; add_cin = flags_i.c; end
      default:        ;
    endcase
  end

  cond_alu_adder #(.DATA_W(DATA_W)) u_adder (
    .x_i    (add_x),
    .y_i    (add_y),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  always_comb begin
    is_logic_o = 1'b1;
    unique case (op)
      OP_AND, OP_TST: logic_res = a_i & b_i;
      OP_EOR, OP_TEQ: logic_res = a_i ^ b_i;
      OP_ORR:         logic_res = a_i | b_i;
      OP_MOV:         logic_res = b_i;
      OP_BIC:         logic_res = a_i & ~b_i;
      OP_MVN:         logic_res = ~b_i;
      default: begin
        logic_res  = '0;
        is_logic_o = 1'b0;
      end
    endcase
  end

  assign is_cmp_o = (opcode_i[3:2] == 2'b10);
  assign result_o = is_logic_o ? logic_res : add_sum;

  always_comb begin
    flags_o.n = result_o[MSB];
    flags_o.z = (result_o == '0);
    if (is_logic_o) begin
      flags_o.c = shift_carry_i;
      flags_o.v = flags_i.v;
    end else begin
      flags_o.c = add_cout;
      flags_o.v = add_ovf;
    end
  end

endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [3:0]        opcode_i,
  input  logic [3:0]        cond_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              set_flags_i,
  input  logic              shift_carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_o,
  output logic [DATA_W-1:0] status_o
);

  localparam int unsigned PAD_W = DATA_W - FLAG_W;

  nzcv_t flags_q, flags_next;
  logic  cond_pass, is_cmp, is_logic, flag_upd;

  cond_alu_cond u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (cond_pass)
  );

  cond_alu_exec #(.DATA_W(DATA_W)) u_exec (
    .opcode_i      (opcode_i),
    .a_i           (op_a_i),
    .b_i           (op_b_i),
    .flags_i       (flags_q),
    .shift_carry_i (shift_carry_i),
    .result_o      (result_o),
    .flags_o       (flags_next),
    .is_cmp_o      (is_cmp),
    .is_logic_o    (is_logic)
  );

  assign wr_en_o  = op_valid_i & cond_pass & ~is_cmp;
  assign flag_upd = op_valid_i & cond_pass & (set_flags_i | is_cmp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= '0;
    else if (flag_upd) flags_q <= flags_next;
  end

  assign flags_o = flags_q;

  generate
    if (PAD_W > 0) begin : g_status_pad
      assign status_o = {flags_q, {PAD_W{1'b0}}};
    end else begin : g_status_bare
      assign status_o = flags_q;
    end
  endgenerate

  assert_fail_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !cond_pass) |-> !wr_en_o);

  assert_fail_keep_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !cond_pass) |=> $stable(flags_o));

  assert_always_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'hE) |-> cond_pass);

  assert_never_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'hF) |-> !cond_pass);

  assert_cmp_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && is_cmp) |-> !wr_en_o);

  assert_idle_keep_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(flags_o));

  assert_logic_keeps_v_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cond_pass && is_logic) |=> (flags_o[0] == $past(flags_o[0])));

  assert_status_pad_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[DATA_W-1 -: FLAG_W] == flags_o);

endmodule

// File: tb/cond_alu_test.sv
module cond_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [3:0]  cond = 4'hE;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        set_flags = 1'b0;
  logic        shift_carry = 1'b0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cond_alu uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .op_valid_i    (op_valid),
    .opcode_i      (opcode),
    .cond_i        (cond),
    .op_a_i        (op_a),
    .op_b_i        (op_b),
    .set_flags_i   (set_flags),
    .shift_carry_i (shift_carry),
    .result_o      (result),
    .wr_en_o       (wr_en),
    .flags_o       (flags),
    .status_o      (status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive, check combinational outputs, clock, check flags
  task automatic issue(input string tag, input logic [3:0] op, input logic [3:0] cc,
                       input logic [31:0] a, input logic [31:0] b, input logic s,
                       input logic sc, input logic [31:0] exp_res, input logic exp_wr,
                       input logic [3:0] exp_flags, input bit check_res);
    @(negedge clk);
    op_valid = 1'b1; opcode = op; cond = cc; op_a = a; op_b = b;
    set_flags = s; shift_carry = sc;
    #2;
    if (check_res) chk({tag, " result"}, result, exp_res);
    chk({tag, " wr_en"}, {31'd0, wr_en}, {31'd0, exp_wr});
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    chk({tag, " flags"}, {28'd0, flags}, {28'd0, exp_flags});
  endtask

  task automatic t_reset;
    chk("R1 reset flags", {28'd0, flags}, 32'd0);
    chk("R1 reset status", status, 32'd0);
  endtask

  task automatic t_add_sub;
    issue("R4 ADD", 4'h4, 4'hE, 32'd5, 32'd3, 1, 0, 32'd8, 1, 4'b0000, 1);
    issue("R4 ADD ovf", 4'h4, 4'hE, 32'h7FFF_FFFF, 32'd1, 1, 0, 32'h8000_0000, 1, 4'b1001, 1);
    issue("R4 SUB zero", 4'h2, 4'hE, 32'd5, 32'd5, 1, 0, 32'd0, 1, 4'b0110, 1);
    issue("R4 SUB borrow", 4'h2, 4'hE, 32'd3, 32'd5, 1, 0, 32'hFFFF_FFFE, 1, 4'b1000, 1);
    issue("R4 RSB", 4'h3, 4'hE, 32'd3, 32'd10, 1, 0, 32'd7, 1, 4'b0010, 1);
  endtask

  task automatic t_carry_forms;
    issue("R5 R9 ADC c1", 4'h5, 4'hE, 32'd1, 32'd1, 0, 0, 32'd3, 1, 4'b0010, 1);
    issue("R5 SBC c1", 4'h6, 4'hE, 32'd10, 32'd3, 1, 0, 32'd7, 1, 4'b0010, 1);
    issue("R5 RSC c1", 4'h7, 4'hE, 32'd3, 32'd10, 0, 0, 32'd7, 1, 4'b0010, 1);
    issue("R8 CMP clear C", 4'hA, 4'hE, 32'd3, 32'd5, 0, 0, 32'd0, 0, 4'b1000, 0);
    issue("R5 ADC c0", 4'h5, 4'hE, 32'd1, 32'd1, 0, 0, 32'd2, 1, 4'b1000, 1);
    issue("R5 SBC c0", 4'h6, 4'hE, 32'd10, 32'd3, 0, 0, 32'd6, 1, 4'b1000, 1);
    issue("R5 RSC c0", 4'h7, 4'hE, 32'd3, 32'd10, 0, 0, 32'd6, 1, 4'b1000, 1);
  endtask

  task automatic t_logic;
    issue("R6 AND", 4'h0, 4'hE, 32'hF0F0, 32'hFF00, 0, 1, 32'hF000, 1, 4'b1000, 1);
    issue("R6 EOR", 4'h1, 4'hE, 32'hF0F0, 32'hFF00, 0, 1, 32'h0FF0, 1, 4'b1000, 1);
    issue("R6 ORR", 4'hC, 4'hE, 32'hF0F0, 32'hFF00, 0, 1, 32'hFFF0, 1, 4'b1000, 1);
    issue("R6 BIC", 4'hE, 4'hE, 32'hF0F0, 32'hFF00, 0, 1, 32'h00F0, 1, 4'b1000, 1);
    issue("R6 MOV", 4'hD, 4'hE, 32'hDEAD, 32'h1234, 0, 1, 32'h1234, 1, 4'b1000, 1);
    issue("R6 MVN", 4'hF, 4'hE, 32'hDEAD, 32'h0, 0, 1, 32'hFFFF_FFFF, 1, 4'b1000, 1);
  endtask

  task automatic t_logic_flags;
    issue("R7 set V", 4'h4, 4'hE, 32'h7FFF_FFFF, 32'd1, 1, 0, 32'h8000_0000, 1, 4'b1001, 1);
    issue("R7 AND flags", 4'h0, 4'hE, 32'd0, 32'hFFFF, 1, 1, 32'd0, 1, 4'b0111, 1);
    issue("R7 MVN flags", 4'hF, 4'hE, 32'd0, 32'd0, 1, 0, 32'hFFFF_FFFF, 1, 4'b1001, 1);
  endtask

  task automatic t_compare;
    issue("R8 TST", 4'h8, 4'hE, 32'd1, 32'd2, 0, 0, 32'd0, 0, 4'b0101, 0);
    issue("R8 TEQ", 4'h9, 4'hE, 32'd5, 32'd5, 0, 1, 32'd0, 0, 4'b0111, 0);
    issue("R8 CMN", 4'hB, 4'hE, 32'hFFFF_FFFF, 32'd1, 0, 0, 32'd0, 0, 4'b0110, 0);
    issue("R8 CMP", 4'hA, 4'hE, 32'd5, 32'd3, 1, 0, 32'd0, 0, 4'b0010, 0);
  endtask

  // probe all 16 condition codes with a non-flag-setting MOV
  task automatic probe_all(input string tag, input logic [3:0] fl, input logic [15:0] mask);
    for (int c = 0; c < 16; c++) begin
      issue($sformatf("R2 %s cond %0d", tag, c), 4'hD, c[3:0], 32'd0, 32'd9, 0, 0,
            32'd9, mask[c], fl, 1);
    end
  endtask

  task automatic t_conditions;
    issue("R2 set ZC", 4'hA, 4'hE, 32'd5, 32'd5, 0, 0, 32'd0, 0, 4'b0110, 0);
    probe_all("ZC", 4'b0110, 16'h66A5);
    issue("R2 set N", 4'hA, 4'hE, 32'd3, 32'd5, 0, 0, 32'd0, 0, 4'b1000, 0);
    probe_all("N", 4'b1000, 16'h6A9A);
    issue("R2 set C", 4'hA, 4'hE, 32'd5, 32'd3, 0, 0, 32'd0, 0, 4'b0010, 0);
    probe_all("C", 4'b0010, 16'h55A6);
    issue("R2 set NV", 4'hB, 4'hE, 32'h7FFF_FFFF, 32'd1, 0, 0, 32'd0, 0, 4'b1001, 0);
    chk("R10 status word", status, 32'h9000_0000);
    probe_all("NV GT pass", 4'b1001, 16'h565A);
    issue("R2 set CV", 4'hA, 4'hE, 32'h8000_0000, 32'd1, 0, 0, 32'd0, 0, 4'b0011, 0);
    chk("R10 status word CV", status, 32'h3000_0000);
    probe_all("CV", 4'b0011, 16'h6966);
  endtask

  task automatic t_failed_cond;
    issue("R3 SUB fails", 4'h2, 4'h0, 32'd0, 32'd0, 1, 0, 32'd0, 0, 4'b0011, 1);
    issue("R3 CMP fails", 4'hA, 4'h0, 32'd5, 32'd5, 1, 0, 32'd0, 0, 4'b0011, 0);
    issue("R3 NV code", 4'h4, 4'hF, 32'd1, 32'd1, 1, 0, 32'd2, 0, 4'b0011, 1);
    issue("R11 NE passes", 4'h4, 4'h1, 32'd1, 32'd1, 1, 0, 32'd2, 1, 4'b0000, 1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    op_valid = 1'b0; opcode = 4'hA; cond = 4'hE; op_a = 32'd3; op_b = 32'd5;
    set_flags = 1'b1;
    #2;
    chk("R10 idle wr_en", {31'd0, wr_en}, 32'd0);
    @(posedge clk);
    #1;
    chk("R10 idle flags", {28'd0, flags}, 32'd0);
  endtask

  initial begin
    #20;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_add_sub();
    t_carry_forms();
    t_logic();
    t_logic_flags();
    t_compare();
    t_conditions();
    t_failed_cond();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule